// File: doc/BRIEF.md
# Logic Self-Test Session Sequencer

This block runs a complete logic built-in self-test session over a set of parallel scan chains. On an accepted start it seeds a pseudorandom pattern generator, clears a 16-bit signature register, and then steps through a fixed schedule. It loads each pattern with scan-enable high. It applies a short burst of functional capture clocks with scan-enable low. It then shifts the captured chain contents out into the signature register. The next pattern shifts in during that same unload. Every phase is clocked by the single test clock, and the sequencer controls it through a chain clock-enable.

The scan chains are a small behavioural model included with the block so that a session gives a real, repeatable signature. Each chain has a fixed length equal to the longest-chain parameter. At the end of a session the block raises a done flag. It holds the final signature on its output and reports whether that signature equals an expected value supplied at a port. Chain contents left from earlier activity never reach the signature, so every session produces the same result.

Top module: `lbist_ctrl`

## Requirements
- R1: After synchronous active-low reset, done, pass, scan_en and chain_clk_en are all 0.
- R2: An accepted session contains exactly (PATTERNS+1)*CHAIN_LEN shift cycles, in which scan_en=1 and chain_clk_en=1. Whenever no session is running, scan_en and chain_clk_en are both 0.
- R3: A session contains PATTERNS capture bursts. Each burst is exactly CAPTURES consecutive cycles with scan_en=0 and chain_clk_en=1, so there are PATTERNS*CAPTURES capture cycles in total.
- R4: The pattern generator is a 16-bit Fibonacci LFSR. It is set to SEED (default 16'hACE1) on an accepted start. In each shift cycle, chain c receives state bit c, and the state then becomes {s[14:0], s[15]^s[13]^s[12]^s[10]}. The state is never zero.
- R5: The signature register is cleared to 0 on an accepted start. It updates only during shift cycles after the first load phase, to {m[14:0],0} ^ (m[15] ? 16'h1021 : 0) ^ v, where bit c of v is the scan output of chain c and all other bits of v are 0.
- R6: In each chain model, a shift moves every cell one place toward the scan output (the top cell) and takes scan-in at cell 0. A capture sets cell i to old cell i-1 of the same chain (with cell 0 taking the old top cell), XOR cell i of chain (c+1) mod CHAINS.
- R7: done rises in the cycle after the last unload shift. It stays high until the next accepted start clears it.
- R8: pass is 1 exactly when done is 1 and signature equals expected_sig. pass is 0 whenever done is 0.
- R9: start is ignored while a session is running. The session's timing and signature are unchanged by it.
- R10: Each session gives the same signature whatever the chains held before it began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Session request, accepted only when idle |
| expected_sig | input | 16 | Reference signature for the pass comparison |
| scan_en | output | 1 | Scan-enable to the chains (1 = shift) |
| chain_clk_en | output | 1 | Clock enable for the chains |
| done | output | 1 | Session finished; held until the next start |
| pass | output | 1 | Signature matches expected_sig, valid while done |
| signature | output | 16 | Current signature register contents |

## Verification
A start request can arrive in the same cycle as an ongoing shift, as the last capture cycle turns into a shift phase, or together with the final unload shift. The bench provokes this with random start pulses injected into running sessions. It then judges that done still appears after exactly (PATTERNS+1)*CHAIN_LEN + PATTERNS*CAPTURES active cycles and that the signature equals the reference computed by the bench's own model. A second overlap is the load of one pattern sharing its shift cycles with the unload of the previous one. Shift and capture cycle totals are counted at the ports, and the signature must match a model that updates the pattern generator, the chains and the signature register at the same edge.

// File: rtl/lbist_pkg.sv
// Shared constants and types for the logic self-test sequencer.
package lbist_pkg;
    localparam int          SIG_W     = 16;
    localparam logic [15:0] MISR_POLY = 16'h1021;
    localparam logic [15:0] PRPG_TAPS = 16'hB400;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SHIFT   = 2'd1,
        PH_CAPTURE = 2'd2
    } phase_t;
endpackage

// File: rtl/lbist_prpg.sv
// Pseudorandom pattern generator: a Fibonacci LFSR that is seeded on demand
// and advances once per shift cycle. The low OUT_W bits feed the scan inputs.
// Assumes SEED is nonzero and TAPS describes a maximal-length polynomial.
module lbist_prpg #(
    parameter int          W     = 16,
    parameter int          OUT_W = 4,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = lbist_pkg::PRPG_TAPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_load,
    input  logic             advance,
    output logic [OUT_W-1:0] pattern
);
    logic [W-1:0] state_q;
    logic         feedback;

    // Parity of the tapped bits forms the bit shifted in.
    always_comb feedback = ^(state_q & TAPS);

    // State register: seed on load, otherwise step when shifting.
    always_ff @(posedge clk) begin
        if (!rst_n)         state_q <= SEED;
        else if (seed_load) state_q <= SEED;
        else if (advance)   state_q <= {state_q[W-2:0], feedback};
    end

    assign pattern = state_q[OUT_W-1:0];

    assert_seeded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (state_q == SEED));
    assert_never_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/lbist_misr.sv
// Multiple-input signature register. It uses a Galois shift with a fixed
// polynomial and XORs one input bit into each of the low IN_W stages.
// Assumes IN_W <= W.
module lbist_misr #(
    parameter int           W    = 16,
    parameter int           IN_W = 4,
    parameter logic [W-1:0] POLY = lbist_pkg::MISR_POLY
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            compress,
    input  logic [IN_W-1:0] din,
    output logic [W-1:0]    sig
);
    logic [W-1:0] sig_q;
    logic [W-1:0] sig_next;

    // Next signature: shift, fold in the polynomial, then merge the inputs.
    always_comb begin
        sig_next = {sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? POLY : '0);
        sig_next[IN_W-1:0] = sig_next[IN_W-1:0] ^ din;
    end

    // Signature register: clear on start, compress on enabled shifts.
    always_ff @(posedge clk) begin
        if (!rst_n)        sig_q <= '0;
        else if (clear)    sig_q <= '0;
        else if (compress) sig_q <= sig_next;
    end

    assign sig = sig_q;

    assert_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sig_q == '0));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !compress) |=> $stable(sig_q));
endmodule

// File: rtl/lbist_scan_model.sv
// Behavioural scan-chain model: CHAINS chains of CHAIN_LEN cells each.
// When shifting, cells move toward the top cell, which is the scan output.
// When capturing, each chain rotates and XORs its neighbour chain in.
// Cells change only while clk_en is high.
module lbist_scan_model #(
    parameter int CHAINS    = 4,
    parameter int CHAIN_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              scan_en,
    input  logic [CHAINS-1:0] scan_in,
    output logic [CHAINS-1:0] scan_out
);
    logic [CHAIN_LEN-1:0] cells_q [CHAINS];
    logic [CHAIN_LEN-1:0] cells_d [CHAINS];

    // Next cell contents for either shift or functional capture.
    always_comb begin
        for (int c = 0; c < CHAINS; c++) begin
            if (scan_en)
                cells_d[c] = {cells_q[c][CHAIN_LEN-2:0], scan_in[c]};
            else
                cells_d[c] = {cells_q[c][CHAIN_LEN-2:0], cells_q[c][CHAIN_LEN-1]}
                             ^ cells_q[(c + 1) % CHAINS];
        end
    end

    // Cell storage, gated by the chain clock enable.
    always_ff @(posedge clk) begin
        for (int c = 0; c < CHAINS; c++) begin
            if (!rst_n)      cells_q[c] <= '0;
            else if (clk_en) cells_q[c] <= cells_d[c];
        end
    end

    for (genvar g = 0; g < CHAINS; g++) begin : g_out
        assign scan_out[g] = cells_q[g][CHAIN_LEN-1];
    end

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(scan_out));
endmodule

// File: rtl/lbist_seq.sv
// Session sequencer. After an accepted start it runs PATTERNS+1 shift phases
// of CHAIN_LEN cycles, with a capture burst of CAPTURES cycles between each
// pair. The first shift phase only loads; later shift phases unload into the
// signature register while the next pattern loads. Start is accepted only
// when idle. Assumes CHAIN_LEN >= 2, PATTERNS >= 1 and CAPTURES >= 1.
module lbist_seq #(
    parameter int CHAIN_LEN = 8,
    parameter int PATTERNS  = 4,
    parameter int CAPTURES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic scan_en,
    output logic clk_en,
    output logic session_init,
    output logic compress,
    output logic done
);
    import lbist_pkg::*;

    localparam int SH_W  = $clog2(CHAIN_LEN);
    localparam int CAP_W = (CAPTURES > 1) ? $clog2(CAPTURES) : 1;
    localparam int PAT_W = $clog2(PATTERNS + 1);

    phase_t           phase_q;
    logic [SH_W-1:0]  sh_cnt_q;
    logic [CAP_W-1:0] cap_cnt_q;
    logic [PAT_W-1:0] pat_cnt_q;
    logic             done_q;
    logic             sh_last, cap_last, pat_last;

    // Terminal-count decodes for the three counters.
    always_comb begin
        sh_last  = (sh_cnt_q == SH_W'(CHAIN_LEN - 1));
        cap_last = (cap_cnt_q == CAP_W'(CAPTURES - 1));
        pat_last = (pat_cnt_q == PAT_W'(PATTERNS));
    end

    // Phase machine with its shift, capture and pattern counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            sh_cnt_q  <= '0;
            cap_cnt_q <= '0;
            pat_cnt_q <= '0;
            done_q    <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q   <= PH_SHIFT;
                        sh_cnt_q  <= '0;
                        cap_cnt_q <= '0;
                        pat_cnt_q <= '0;
                        done_q    <= 1'b0;
                    end
                end
                PH_SHIFT: begin
                    sh_cnt_q <= sh_cnt_q + 1'b1;
                    if (sh_last) begin
                        sh_cnt_q <= '0;
                        if (pat_last) begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            phase_q <= PH_CAPTURE;
                        end
                    end
                end
                PH_CAPTURE: begin
                    cap_cnt_q <= cap_cnt_q + 1'b1;
                    if (cap_last) begin
                        cap_cnt_q <= '0;
                        pat_cnt_q <= pat_cnt_q + 1'b1;
                        phase_q   <= PH_SHIFT;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Control outputs decoded from the phase.
    always_comb begin
        scan_en      = (phase_q == PH_SHIFT);
        clk_en       = (phase_q != PH_IDLE);
        session_init = (phase_q == PH_IDLE) && start;
        compress     = (phase_q == PH_SHIFT) && (pat_cnt_q != '0);
    end

    assign done = done_q;

    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> (!scan_en && !clk_en));
    assert_capture_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CAPTURE && !cap_last) |=> (phase_q == PH_CAPTURE));
    assert_done_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHIFT && sh_last && pat_last) |=> (done_q && phase_q == PH_IDLE));
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CAPTURE && start) |=> (phase_q != PH_IDLE && !done_q));
    assert_done_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (phase_q == PH_IDLE));
endmodule

// File: rtl/lbist_ctrl.sv
// Top of the logic self-test block. It ties the sequencer to the pattern
// generator, the chain model and the signature register, and compares the
// final signature against an expected value. Assumes CHAINS <= 16.
module lbist_ctrl #(
    parameter int          CHAINS    = 4,
    parameter int          CHAIN_LEN = 8,
    parameter int          PATTERNS  = 4,
    parameter int          CAPTURES  = 2,
    parameter logic [15:0] SEED      = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] expected_sig,
    output logic        scan_en,
    output logic        chain_clk_en,
    output logic        done,
    output logic        pass,
    output logic [15:0] signature
);
    import lbist_pkg::*;

    logic              session_init;
    logic              compress;
    logic [CHAINS-1:0] chain_in;
    logic [CHAINS-1:0] chain_out;

    lbist_seq #(
        .CHAIN_LEN(CHAIN_LEN), .PATTERNS(PATTERNS), .CAPTURES(CAPTURES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .scan_en(scan_en), .clk_en(chain_clk_en),
        .session_init(session_init), .compress(compress), .done(done)
    );

    lbist_prpg #(
        .W(SIG_W), .OUT_W(CHAINS), .SEED(SEED), .TAPS(PRPG_TAPS)
    ) u_prpg (
        .clk(clk), .rst_n(rst_n), .seed_load(session_init),
        .advance(scan_en), .pattern(chain_in)
    );

    lbist_scan_model #(
        .CHAINS(CHAINS), .CHAIN_LEN(CHAIN_LEN)
    ) u_chains (
        .clk(clk), .rst_n(rst_n), .clk_en(chain_clk_en), .scan_en(scan_en),
        .scan_in(chain_in), .scan_out(chain_out)
    );

    lbist_misr #(
        .W(SIG_W), .IN_W(CHAINS), .POLY(MISR_POLY)
    ) u_misr (
        .clk(clk), .rst_n(rst_n), .clear(session_init), .compress(compress),
        .din(chain_out), .sig(signature)
    );

    // Verdict: meaningful only once the session has finished.
    always_comb pass = done && (signature == expected_sig);

    assert_no_pass_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chain_clk_en |-> !pass);
    assert_shift_has_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> chain_clk_en);
endmodule

// File: tb/lbist_ctrl_bench.sv
module lbist_ctrl_bench;
    localparam int          NC   = 4;
    localparam int          NL   = 8;
    localparam int          NP   = 4;
    localparam int          NCAP = 2;
    localparam logic [15:0] SEED = 16'hACE1;
    localparam int          ACTIVE = (NP + 1) * NL + NP * NCAP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] expected_sig = '0;
    logic        scan_en, chain_clk_en, done, pass;
    logic [15:0] signature;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] ref_sig;

    lbist_ctrl #(
        .CHAINS(NC), .CHAIN_LEN(NL), .PATTERNS(NP), .CAPTURES(NCAP), .SEED(SEED)
    ) u_lbist_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .expected_sig(expected_sig),
        .scan_en(scan_en), .chain_clk_en(chain_clk_en), .done(done),
        .pass(pass), .signature(signature)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference signature from R4, R5 and R6, computed per pattern.
    function automatic logic [15:0] model_sig();
        logic [15:0]   p = SEED;
        logic [15:0]   m = '0;
        logic [NL-1:0] ch [NC];
        logic [NL-1:0] old [NC];
        logic [15:0]   v;
        for (int c = 0; c < NC; c++) ch[c] = '0;
        for (int pat = 0; pat <= NP; pat++) begin
            for (int s = 0; s < NL; s++) begin
                v = '0;
                for (int c = 0; c < NC; c++) v[c] = ch[c][NL-1];
                if (pat > 0) m = {m[14:0], 1'b0} ^ (m[15] ? 16'h1021 : 16'h0) ^ v;
                for (int c = 0; c < NC; c++) ch[c] = {ch[c][NL-2:0], p[c]};
                p = {p[14:0], p[15] ^ p[13] ^ p[12] ^ p[10]};
            end
            if (pat < NP) begin
                for (int k = 0; k < NCAP; k++) begin
                    for (int c = 0; c < NC; c++) old[c] = ch[c];
                    for (int c = 0; c < NC; c++)
                        ch[c] = {old[c][NL-2:0], old[c][NL-1]} ^ old[(c + 1) % NC];
                end
            end
        end
        return m;
    endfunction

    // One session; inject random start pulses mid-run when noisy is set.
    task automatic run_session(input logic [15:0] exp_in, input bit noisy);
        int n_shift = 0, n_cap = 0, run = 0, bad_run = 0, early = 0;
        expected_sig = exp_in;
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= ACTIVE; k++) begin
            @(negedge clk);
            if (scan_en && chain_clk_en) n_shift++;
            if (!scan_en && chain_clk_en) begin n_cap++; run++; end
            else begin
                if (run != 0 && run != NCAP) bad_run++;
                run = 0;
            end
            if (done || pass) early++;
            start = (noisy && k < ACTIVE) ? 1'($urandom_range(0, 2) == 0) : 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        check(n_shift == ACTIVE - NP * NCAP, "R2", "shift cycles", n_shift, ACTIVE - NP * NCAP);
        check(n_cap == NP * NCAP, "R3", "capture cycles", n_cap, NP * NCAP);
        check(bad_run == 0, "R3", "capture burst length", bad_run, 0);
        check(early == 0, "R7", "done/pass before end (R8 too)", early, 0);
        check(done == 1'b1, noisy ? "R9" : "R7", "done after last shift", done, 1);
        check(!scan_en && !chain_clk_en, "R2", "idle outputs after session",
              {scan_en, chain_clk_en}, 0);
        // Signature depends on R4, R5, R6; repeatability is R10.
        check(signature == ref_sig, noisy ? "R9" : "R10", "signature", signature, ref_sig);
        check(pass == (exp_in == ref_sig), "R8", "pass flag", pass, exp_in == ref_sig);
    endtask

    initial begin
        for (int w = 0; w < 100000; w++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual %0d expected %0d", n_tests, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        ref_sig = model_sig();
        repeat (3) @(negedge clk);
        check({done, pass, scan_en, chain_clk_en} == 4'b0, "R1", "reset outputs",
              {done, pass, scan_en, chain_clk_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({done, pass, scan_en, chain_clk_en} == 4'b0, "R1", "after reset release",
              {done, pass, scan_en, chain_clk_en}, 0);

        run_session(ref_sig, 1'b0);          // matching reference
        repeat (4) @(negedge clk);
        check(done == 1'b1 && pass == 1'b1, "R7", "done held while idle", done, 1);
        run_session(ref_sig ^ 16'h0001, 1'b0); // mismatch in one bit (R8)
        run_session(ref_sig, 1'b1);            // start pulses mid-session (R9)

        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(done == 1'b0, "R7", "done cleared by new start", done, 0);
        check(signature == 16'h0, "R5", "signature cleared on start", signature, 0);
        while (!done) @(negedge clk);
        check(signature == ref_sig, "R10", "back-to-back session", signature, ref_sig);

        for (int i = 0; i < 6; i++) begin
            logic [15:0] e;
            e = ($urandom_range(0, 1) == 1) ? ref_sig : ref_sig ^ (16'h1 << $urandom_range(0, 15));
            repeat ($urandom_range(0, 5)) @(negedge clk);
            run_session(e, 1'($urandom_range(0, 1)));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule